// File: doc/BRIEF.md
# Paged memory address pointer

This block keeps the internal location pointer for a 272-byte storage array built as 17 pages of 16 bytes each. When the protocol engine receives an address byte, it pulses a load strobe. The block then turns the byte into a 9-bit location and records which kind of operation is in progress. After each data byte the engine pulses an advance strobe, and the pointer steps forward. A page write steps only within the current page. A read or a byte write steps through the whole array and returns to the start after the last location.

For every data byte the block also works out whether an array write is allowed. The decision uses the write-enable latch, the operation recorded at load time, and the location the pointer holds now. When a write is refused, the protocol engine still completes the transfer. It simply does not strobe the array.

Top module: `page_addr_ptr`

## Requirements
- R1: On a load, address bytes 00h..FEh set the pointer to the same location, and address byte FFh sets it to location 100h.
- R2: The operation code `op_i` is registered at load. The encodings are 00 byte write, 01 page write, 10 read and 11 read. While the registered operation is a page write, each advance increments bits [3:0] of the pointer modulo 16 and leaves bits [8:4] unchanged.
- R3: A page write that advances more than 16 times keeps cycling through the same 16 offsets. For example, 12 advances from offset 11 leave the pointer at offset 7 of the same page.
- R4: While the registered operation is a read or a byte write, each advance increments the pointer by one, and from 10Fh it goes to 00h.
- R5: When a page write points into page 8 (locations 80h..8Fh), `wr_permit_o` is 0.
- R6: `wr_permit_o` is 0 whenever `wel_i` is 0 or the registered operation is a read. A page write outside page 8 with `wel_i`=1 is permitted.
- R7: A byte write with `wel_i`=1 is permitted only at locations 00h..FEh and 100h. It is refused at FFh and at 101h..10Fh.
- R8: Changing `op_i` without a load has no effect on pointer stepping or on the permit decision.
- R9: After reset the pointer is 000h, the registered operation is read, and `wr_permit_o` is 0.
- R10: If load and advance occur in the same cycle, load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Address byte received; load the pointer |
| addr_byte_i | input | 8 | Received address byte |
| op_i | input | 2 | Operation type, sampled on load |
| advance_i | input | 1 | Data byte done; step the pointer |
| wel_i | input | 1 | Write-enable latch state |
| addr_o | output | 9 | Current array location |
| wr_permit_o | output | 1 | Write to `addr_o` allowed for this byte |

## Verification
A wrong pointer shows up on `addr_o` one cycle after the load or advance that caused it. A bad page step moves the pointer out of its page, and a bad read wrap leaves the pointer beyond 10Fh. A stale or corrupted operation register does not change the address on the cycle it happens. It shows up later, either as a different step pattern on the following advance or as a wrong `wr_permit_o` at the same location. For that reason every address byte is followed by a run of 20 advances, with `op_i` deliberately changed after the load.

// File: rtl/page_ptr_pkg.sv
package page_ptr_pkg;
  typedef enum logic [1:0] {
    OP_BYTE_WR = 2'b00,
    OP_PAGE_WR = 2'b01,
    OP_READ    = 2'b10,
    OP_READ_ALT = 2'b11
  } op_e;
endpackage

// File: rtl/ptr_remap.sv
module ptr_remap #(
  parameter int ABYTE_W = 8,
  parameter int ADDR_W  = 9
) (
  input  logic [ABYTE_W-1:0] addr_byte_i,
  output logic [ADDR_W-1:0]  loc_o
);
  localparam logic [ADDR_W-1:0] HI_LOC = ADDR_W'(1) << ABYTE_W;

  // all-ones address byte reaches the extra page above the byte range
  always_comb begin
    if (&addr_byte_i) loc_o = HI_LOC;
    else              loc_o = ADDR_W'(addr_byte_i);
  end
endmodule

// File: rtl/ptr_step.sv
module ptr_step #(
  parameter int ADDR_W = 9,
  parameter int OFS_W  = 4,
  parameter int DEPTH  = 272
) (
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              in_page_i,
  output logic [ADDR_W-1:0] next_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] page_next, lin_next;
  logic [OFS_W-1:0]  ofs_inc;

  always_comb begin
    ofs_inc   = ptr_i[OFS_W-1:0] + OFS_W'(1);
    page_next = {ptr_i[ADDR_W-1:OFS_W], ofs_inc};
    lin_next  = (ptr_i == LAST) ? '0 : ptr_i + ADDR_W'(1);
    next_o    = in_page_i ? page_next : lin_next;
  end
endmodule

// File: rtl/wr_gate.sv
module wr_gate
  import page_ptr_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int OFS_W     = 4,
  parameter int ABYTE_W   = 8,
  parameter int PROT_PAGE = 8
) (
  input  logic [ADDR_W-1:0] ptr_i,
  input  op_e               op_i,
  input  logic              wel_i,
  output logic              permit_o
);
  localparam int PG_W = ADDR_W - OFS_W;
  localparam logic [ADDR_W-1:0] HI_LOC = ADDR_W'(1) << ABYTE_W;

  logic byte_ok, page_ok;

  always_comb begin
    byte_ok = (ptr_i < HI_LOC - ADDR_W'(1)) || (ptr_i == HI_LOC);
    page_ok = ptr_i[ADDR_W-1:OFS_W] != PG_W'(PROT_PAGE);
    unique case (op_i)
      OP_BYTE_WR: permit_o = wel_i & byte_ok;
      OP_PAGE_WR: permit_o = wel_i & page_ok;
      default:    permit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/page_addr_ptr.sv
module page_addr_ptr
  import page_ptr_pkg::*;
#(
  parameter int OFS_W     = 4,
  parameter int NUM_PAGES = 17,
  parameter int ABYTE_W   = 8,
  parameter int PROT_PAGE = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [ABYTE_W-1:0] addr_byte_i,
  input  logic [1:0]         op_i,
  input  logic               advance_i,
  input  logic               wel_i,
  output logic [$clog2(NUM_PAGES*(1<<OFS_W))-1:0] addr_o,
  output logic               wr_permit_o
);
  localparam int DEPTH  = NUM_PAGES * (1 << OFS_W);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PG_W   = ADDR_W - OFS_W;
  localparam logic [ADDR_W-1:0] LAST   = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] HI_LOC = ADDR_W'(1) << ABYTE_W;

  logic [ADDR_W-1:0] ptr_q, load_loc, step_loc;
  op_e               op_q;

  ptr_remap #(.ABYTE_W(ABYTE_W), .ADDR_W(ADDR_W)) i_remap (
    .addr_byte_i(addr_byte_i),
    .loc_o      (load_loc)
  );

  ptr_step #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DEPTH(DEPTH)) i_step (
    .ptr_i    (ptr_q),
    .in_page_i(op_q == OP_PAGE_WR),
    .next_o   (step_loc)
  );

  wr_gate #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .ABYTE_W(ABYTE_W),
            .PROT_PAGE(PROT_PAGE)) i_gate (
    .ptr_i   (ptr_q),
    .op_i    (op_q),
    .wel_i   (wel_i),
    .permit_o(wr_permit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      op_q  <= OP_READ;
    end else if (load_i) begin
      ptr_q <= load_loc;
      op_q  <= op_e'(op_i);
    end else if (advance_i) begin
      ptr_q <= step_loc;
    end
  end

  assign addr_o = ptr_q;

  // R1
  ff_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (&addr_byte_i) |=> addr_o == HI_LOC);

  // R2
  page_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && advance_i && op_q == OP_PAGE_WR
    |=> addr_o[ADDR_W-1:OFS_W] == $past(addr_o[ADDR_W-1:OFS_W]));

  // R4
  read_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && advance_i && op_q != OP_PAGE_WR && addr_o == LAST
    |=> addr_o == '0);

  // R4
  in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o <= LAST);

  // R5
  prot_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_permit_o && op_q == OP_PAGE_WR
    |-> addr_o[ADDR_W-1:OFS_W] != PG_W'(PROT_PAGE));

  // R6
  wel_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_permit_o |-> wel_i && op_q != OP_READ && op_q != OP_READ_ALT);

  // R7
  byte_hole_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_permit_o && op_q == OP_BYTE_WR |-> addr_o != HI_LOC - ADDR_W'(1));

  // R8
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(op_q));

  // R10
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && advance_i |=> addr_o == $past(load_loc));
endmodule

// File: tb/test_page_addr_ptr.sv
`timescale 1ns/1ps
module test_page_addr_ptr;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] addr_byte_i = '0;
  logic [1:0] op_i = 2'b10;
  logic       advance_i = 1'b0;
  logic       wel_i = 1'b1;
  logic [8:0] addr_o;
  logic       wr_permit_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  page_addr_ptr i_page_addr_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .addr_byte_i(addr_byte_i),
    .op_i(op_i), .advance_i(advance_i), .wel_i(wel_i),
    .addr_o(addr_o), .wr_permit_o(wr_permit_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_perm(input int op, input int p, input bit wel);
    if (!wel) return 1'b0;
    case (op)
      0: return (p <= 254) || (p == 256);
      1: return (p / 16) != 8;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int exp_next(input int op, input int p);
    if (op == 1) return (p / 16) * 16 + ((p % 16) + 1) % 16;
    return (p == 271) ? 0 : p + 1;
  endfunction

  function automatic string perm_tag(input int op, input int p);
    if (op == 1 && (p / 16) == 8) return "R5";
    if (op == 0) return "R7";
    return "R6";
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R9 addr", addr_o, 0);
    chk("R9 permit", wr_permit_o, 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R9 addr after release", addr_o, 0);
    chk("R9 permit after release", wr_permit_o, 0);

    for (int op = 0; op < 4; op++) begin
      for (int b = 0; b < 256; b++) begin
        int p;
        int eop;
        eop = (op == 3) ? 2 : op;
        load_i      = 1'b1;
        addr_byte_i = 8'(b);
        op_i        = 2'(op);
        advance_i   = b[0];
        wel_i       = 1'b1;
        @(posedge clk_i); #1;
        load_i    = 1'b0;
        advance_i = 1'b0;
        op_i      = 2'((op + 1) % 4);
        p = (b == 255) ? 256 : b;
        chk(b[0] ? "R10 load over advance" : "R1 load", addr_o, p);
        chk(perm_tag(eop, p), wr_permit_o, exp_perm(eop, p, 1'b1));
        wel_i = 1'b0; #1;
        chk("R6 wel low", wr_permit_o, 0);
        wel_i = 1'b1; #1;
        for (int k = 0; k < 20; k++) begin
          advance_i = 1'b1;
          @(posedge clk_i); #1;
          p = exp_next(eop, p);
          if (eop == 1) chk(k >= 16 ? "R3/R8 page wrap" : "R2/R8 page step", addr_o, p);
          else          chk("R4/R8 linear step", addr_o, p);
          chk(perm_tag(eop, p), wr_permit_o, exp_perm(eop, p, 1'b1));
        end
        advance_i = 1'b0;
      end
    end

    // R3: 12 bytes from offset 11 of page 2 end at offset 7
    load_i = 1'b1; addr_byte_i = 8'h2B; op_i = 2'b01;
    @(posedge clk_i); #1;
    load_i = 1'b0;
    advance_i = 1'b1;
    repeat (12) @(posedge clk_i);
    #1;
    advance_i = 1'b0;
    chk("R3 twelve bytes from offset 11", addr_o, 9'h027);

    summary();
    $finish;
  end
endmodule